// File: doc/BRIEF.md
# Video Memory Byte Port with Read-Ahead Word Buffer

This block sits between a byte-wide processor register bus and a video memory built from 16-bit words. Software sets a word address by writing it one byte at a time, selects an auto-increment rule through a mode register, and then moves data through low-byte and high-byte data registers. It never waits on the memory.

Reads are served from a one-word read-ahead buffer. The buffer is refilled from memory whenever the address changes through the address registers. It is also refilled whenever a data read hits the byte lane chosen as the increment trigger. A read therefore returns the word fetched before the access, not the word at the current address.

The step is 1, 32 or 128 words and wraps at the top of the 16-bit address space. An address-mapping selector is kept in the mode register and made visible to the neighbouring logic, but addresses reach the memory unchanged.

Top module: `vram_port`

## Requirements
- R1: After reset the returned byte `bus_rdata` is 0, the word address is 0, the read-ahead buffer holds 0, the trigger is the low byte, the step is one word and `map_sel` is 0.
- R2: A write of either address byte (select 1 = low byte, select 2 = high byte) issues a memory read of the new address in the same cycle and refills the buffer with that word. A data read in the very next cycle already sees the refilled word.
- R3: A data read (select 5 = low byte, select 6 = high byte) returns on `bus_rdata`, from the cycle after the strobe, the matching byte of the buffer as it stood before the access.
- R4: A data read on the trigger lane refills the buffer from the address held before the increment and then advances the address by the step.
- R5: A data read on the other lane changes neither the buffer nor the address and issues no memory access.
- R6: A data write (select 3 = low byte, select 4 = high byte) drives `mem_wr` with exactly one byte enable: `mem_be[0]` for the low byte, `mem_be[1]` for the high byte. The data byte appears on both lanes of `mem_wdata`, and `mem_addr` is the current word address.
- R7: A data write advances the address only when its lane is the trigger lane.
- R8: Mode register (select 0) bit 7 picks the trigger lane (0 low, 1 high). Bits 1:0 pick the step: 00 = 1 word, 01 = 32 words, 10 and 11 = 128 words.
- R9: Address increments wrap modulo 65536 words.
- R10: Mode bits 3:2 are stored and shown on `map_sel`. They do not alter `mem_addr`, and a mode write causes no memory access.
- R11: `bus_rdata` holds the last byte returned. A read of select 0, 1, 2, 3, 4 or 7 returns that byte unchanged, and only a data read changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 3 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Returned byte (held bus value) |
| map_sel | output | 2 | Stored address-mapping selector |
| mem_rd | output | 1 | Memory word read request |
| mem_wr | output | 1 | Memory byte write request |
| mem_be | output | 2 | Byte-lane enables for writes |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write data, byte on both lanes |
| mem_rdata | input | 16 | Read word, valid the cycle after `mem_rd` |

## Verification
A stale or corrupted buffer shows up on the next data read, one cycle after its strobe. Because reads return the pre-access buffer, a wrong refill source (for example the post-increment address) surfaces one read later than the fault.

A wrong address or step is caught right away on `mem_addr` during data writes. It is caught again indirectly when read-back data does not match a shadow memory.

A wrong trigger decision shows within one cycle as a missing or spurious `mem_rd`. It shows one read later as repeated or skipped words.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

    // register select codes seen on the byte bus
    typedef enum logic [2:0] {
        SEL_MODE    = 3'd0,
        SEL_ADDR_LO = 3'd1,
        SEL_ADDR_HI = 3'd2,
        SEL_WR_LO   = 3'd3,
        SEL_WR_HI   = 3'd4,
        SEL_RD_LO   = 3'd5,
        SEL_RD_HI   = 3'd6,
        SEL_SPARE   = 3'd7
    } port_sel_e;

    // step encoding held in mode bits 1:0
    typedef enum logic [1:0] {
        STEP_ONE  = 2'd0,
        STEP_MID  = 2'd1,
        STEP_BIG0 = 2'd2,
        STEP_BIG1 = 2'd3
    } step_code_e;

endpackage

// File: rtl/vport_addr_ctr.sv
module vport_addr_ctr #(
    parameter int ADDR_W   = 16,
    parameter int BYTE_W   = 8,
    parameter int STEP_MED = 32,
    parameter int STEP_LRG = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [BYTE_W-1:0] ld_byte,
    input  logic              adv,
    input  logic [1:0]        step_sel,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] addr_nx
);
    import vram_port_pkg::*;

    localparam int HI_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] step_w;

    always_comb begin
        case (step_code_e'(step_sel))
            STEP_ONE: step_w = ADDR_W'(1);
            STEP_MID: step_w = ADDR_W'(STEP_MED);
            default:  step_w = ADDR_W'(STEP_LRG);
        endcase
    end

    always_comb begin
        addr_d = addr_q;
        if (ld_lo) begin
            addr_d[BYTE_W-1:0] = ld_byte;
        end else if (ld_hi) begin
            addr_d[ADDR_W-1:BYTE_W] = ld_byte[HI_W-1:0];
        end else if (adv) begin
            // natural wrap at 2**ADDR_W
            addr_d = addr_q + step_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_nx = addr_d;

endmodule

// File: rtl/vport_prefetch.sv
module vport_prefetch #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] cur_word
);
    typedef struct packed {
        logic              pend;
        logic [WORD_W-1:0] word;
    } pf_st_t;

    pf_st_t st_d, st_q;

    always_comb begin
        // a refill in flight lands this cycle: forward it
        cur_word   = st_q.pend ? mem_rdata : st_q.word;
        st_d.word  = cur_word;
        st_d.pend  = issue;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/vram_port.sv
module vram_port #(
    parameter int ADDR_W   = 16,
    parameter int BYTE_W   = 8,
    parameter int STEP_MED = 32,
    parameter int STEP_LRG = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_sel,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    output logic [1:0]          map_sel,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [1:0]          mem_be,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [2*BYTE_W-1:0] mem_wdata,
    input  logic [2*BYTE_W-1:0] mem_rdata
);
    import vram_port_pkg::*;

    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic              hi_trig;
        logic [1:0]        map;
        logic [1:0]        step;
        logic [BYTE_W-1:0] bus;
    } port_st_t;

    port_st_t st_d, st_q;

    port_sel_e         sel;
    logic              rd_act;
    logic              wr_mode, wr_alo, wr_ahi, wr_dlo, wr_dhi;
    logic              rd_dlo, rd_dhi;
    logic              trig_hi;
    logic              rd_hit, wr_hit, adv, fetch;
    logic [ADDR_W-1:0] addr_q, addr_nx;
    logic [WORD_W-1:0] cur_word;

    assign sel     = port_sel_e'(bus_sel);
    assign rd_act  = bus_rd & ~bus_wr;
    assign trig_hi = st_q.hi_trig;

    assign wr_mode = bus_wr && (sel == SEL_MODE);
    assign wr_alo  = bus_wr && (sel == SEL_ADDR_LO);
    assign wr_ahi  = bus_wr && (sel == SEL_ADDR_HI);
    assign wr_dlo  = bus_wr && (sel == SEL_WR_LO);
    assign wr_dhi  = bus_wr && (sel == SEL_WR_HI);
    assign rd_dlo  = rd_act && (sel == SEL_RD_LO);
    assign rd_dhi  = rd_act && (sel == SEL_RD_HI);

    assign rd_hit  = (rd_dlo & ~trig_hi) | (rd_dhi & trig_hi);
    assign wr_hit  = (wr_dlo & ~trig_hi) | (wr_dhi & trig_hi);
    assign adv     = rd_hit | wr_hit;
    assign fetch   = wr_alo | wr_ahi | rd_hit;

    vport_addr_ctr #(
        .ADDR_W  (ADDR_W),
        .BYTE_W  (BYTE_W),
        .STEP_MED(STEP_MED),
        .STEP_LRG(STEP_LRG)
    ) addr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (wr_alo),
        .ld_hi   (wr_ahi),
        .ld_byte (bus_wdata),
        .adv     (adv),
        .step_sel(st_q.step),
        .addr_q  (addr_q),
        .addr_nx (addr_nx)
    );

    vport_prefetch #(
        .WORD_W(WORD_W)
    ) pf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (fetch),
        .mem_rdata(mem_rdata),
        .cur_word (cur_word)
    );

    always_comb begin
        st_d = st_q;
        if (wr_mode) begin
            st_d.hi_trig = bus_wdata[7];
            st_d.map     = bus_wdata[3:2];
            st_d.step    = bus_wdata[1:0];
        end
        if (rd_dlo)      st_d.bus = cur_word[BYTE_W-1:0];
        else if (rd_dhi) st_d.bus = cur_word[WORD_W-1:BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // mapping selector is carried but addresses pass straight through;
    // an address write fetches the freshly composed address
    assign mem_addr  = (wr_alo | wr_ahi) ? addr_nx : addr_q;
    assign mem_rd    = fetch;
    assign mem_wr    = wr_dlo | wr_dhi;
    assign mem_be    = {wr_dhi, wr_dlo};
    assign mem_wdata = {bus_wdata, bus_wdata};
    assign bus_rdata = st_q.bus;
    assign map_sel   = st_q.map;

endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [1:0]        mem_be,
    input logic              trig_hi
);
    logic data_rd_hit, data_rd_miss;
    assign data_rd_hit  = bus_rd && !bus_wr &&
                          ((bus_sel == 3'd5 && !trig_hi) || (bus_sel == 3'd6 && trig_hi));
    assign data_rd_miss = bus_rd && !bus_wr &&
                          ((bus_sel == 3'd5 && trig_hi) || (bus_sel == 3'd6 && !trig_hi));

    p_single_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_lane_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $countones(mem_be) == 1);

    p_addr_refill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_sel == 3'd1 || bus_sel == 3'd2)) |-> mem_rd);

    p_hit_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd_hit |-> mem_rd);

    p_miss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd_miss |-> !mem_rd && !mem_wr);

    p_mode_no_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 3'd0) |-> !mem_rd && !mem_wr);

    p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind vram_port vram_port_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_be   (mem_be),
    .trig_hi  (trig_hi)
);

// File: tb/vram_port_tb_top.sv
module vram_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  map_sel;
    logic        mem_rd, mem_wr;
    logic [1:0]  mem_be;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vram_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .map_sel(map_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model seen by the design, and a separate shadow for expectations
    logic [15:0] ram_a [int unsigned];
    logic [15:0] shd_a [int unsigned];

    function automatic logic [15:0] seed(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    logic [15:0] ram_w;
    always @(posedge clk) begin
        if (mem_wr) begin
            ram_w = ram_a.exists(32'(mem_addr)) ? ram_a[32'(mem_addr)] : seed(mem_addr);
            if (mem_be[0]) ram_w[7:0]  = mem_wdata[7:0];
            if (mem_be[1]) ram_w[15:8] = mem_wdata[15:8];
            ram_a[32'(mem_addr)] = ram_w;
        end
        if (mem_rd)
            mem_rdata <= ram_a.exists(32'(mem_addr)) ? ram_a[32'(mem_addr)] : seed(mem_addr);
    end

    function automatic logic [15:0] shd_rd(input logic [15:0] a);
        return shd_a.exists(32'(a)) ? shd_a[32'(a)] : seed(a);
    endfunction

    // reference state
    logic [15:0] m_addr = '0, m_buf = '0;
    logic        m_trig = 1'b0;
    logic [1:0]  m_step = '0;
    logic [7:0]  m_bus = '0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] step_of(input logic [1:0] c);
        return (c == 2'd0) ? 16'd1 : (c == 2'd1) ? 16'd32 : 16'd128;
    endfunction

    task automatic drive(input logic [2:0] s, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_rd = r; bus_wdata = d;
    endtask

    task automatic t_idle();
        drive(3'd7, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_mode(input logic trig, input logic [1:0] map, input logic [1:0] step);
        drive(3'd0, 1'b1, 1'b0, {trig, 3'b000, map, step});
        m_trig = trig; m_step = step;
    endtask

    task automatic t_addr(input logic hi, input logic [7:0] b);
        drive(hi ? 3'd2 : 3'd1, 1'b1, 1'b0, b);
        if (hi) m_addr[15:8] = b; else m_addr[7:0] = b;
        m_buf = shd_rd(m_addr);
    endtask

    task automatic t_read(input logic hi, input string tag);
        logic [7:0] b;
        drive(hi ? 3'd6 : 3'd5, 1'b0, 1'b1, 8'h00);
        b = hi ? m_buf[15:8] : m_buf[7:0];
        m_bus = b;
        exp_q.push_back(b);
        tag_q.push_back(tag);
        if (hi == m_trig) begin
            m_buf  = shd_rd(m_addr);
            m_addr = m_addr + step_of(m_step);
        end
    endtask

    task automatic t_read_other(input logic [2:0] s, input string tag);
        drive(s, 1'b0, 1'b1, 8'h00);
        exp_q.push_back(m_bus);
        tag_q.push_back(tag);
    endtask

    task automatic t_write(input logic hi, input logic [7:0] b);
        logic [15:0] w;
        drive(hi ? 3'd4 : 3'd3, 1'b1, 1'b0, b);
        #1;
        check(mem_wr === 1'b1, "R6 write strobe", 32'(mem_wr), 1);
        check(mem_be === (hi ? 2'b10 : 2'b01), "R6 lane enable", 32'(mem_be), hi ? 2 : 1);
        check(mem_wdata === {b, b}, "R6 write data", 32'(mem_wdata), 32'({b, b}));
        check(mem_addr === m_addr, "R7 R9 R10 write address", 32'(mem_addr), 32'(m_addr));
        w = shd_rd(m_addr);
        if (hi) w[15:8] = b; else w[7:0] = b;
        shd_a[32'(m_addr)] = w;
        if (hi == m_trig) m_addr = m_addr + step_of(m_step);
    endtask

    // scoreboard monitor
    logic took = 1'b0;
    always @(posedge clk) took <= rst_n && bus_rd && !bus_wr;

    always @(negedge clk) begin
        if (took) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected read result", 32'(bus_rdata), 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, 32'(bus_rdata), 32'(e));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bus_rdata === 8'h00, "R1 reset bus byte", 32'(bus_rdata), 0);
        check(map_sel === 2'b00, "R1 reset map selector", 32'(map_sel), 0);
        check(!mem_rd && !mem_wr, "R1 no memory access in reset", 32'({mem_rd, mem_wr}), 0);
        rst_n = 1'b1;

        // defaults: low trigger, step 1, empty buffer
        t_read(1'b0, "R1 R3 first read returns reset buffer");
        t_read(1'b0, "R1 R4 refill from word 0");
        t_read(1'b1, "R5 high read without trigger");

        // address write then immediate read (forwarding)
        t_addr(1'b1, 8'h12);
        t_addr(1'b0, 8'h34);
        t_read(1'b0, "R2 back-to-back read after address write");
        t_read(1'b1, "R2 R5 high byte of refilled word");
        t_idle();
        t_read(1'b0, "R4 refill from pre-increment address");

        // high trigger, step 32
        t_mode(1'b1, 2'b00, 2'b01);
        t_addr(1'b1, 8'h01);
        t_addr(1'b0, 8'h00);
        t_write(1'b0, 8'hAB);
        t_write(1'b1, 8'hCD);
        t_write(1'b1, 8'hEE);
        t_addr(1'b1, 8'h01);
        t_addr(1'b0, 8'h00);
        t_read(1'b0, "R5 low read does not refill");
        t_read(1'b0, "R5 low read again same byte");
        t_read(1'b1, "R8 R4 high trigger read");
        t_read(1'b1, "R4 repeat of pre-increment word");
        t_read(1'b1, "R8 step 32 next word");
        t_read(1'b0, "R8 low byte of stepped word");

        // open-bus behaviour
        t_read_other(3'd7, "R11 spare select returns held byte");
        t_read_other(3'd0, "R11 mode select returns held byte");
        t_read_other(3'd3, "R11 write select returns held byte");

        // step 128 (code 3), wrap, mapping selector
        t_mode(1'b0, 2'b10, 2'b11);
        t_idle();
        check(map_sel === 2'b10, "R10 map selector stored", 32'(map_sel), 2);
        t_addr(1'b1, 8'hFF);
        t_addr(1'b0, 8'hC0);
        t_write(1'b0, 8'h11);
        t_write(1'b0, 8'h22);
        t_write(1'b1, 8'h33);
        t_addr(1'b1, 8'hFF);
        t_addr(1'b0, 8'hC0);
        t_read(1'b0, "R9 read before wrap");
        t_read(1'b0, "R9 same word refetched");
        t_read(1'b0, "R9 wrapped word low");
        t_read(1'b1, "R9 wrapped word high");

        // step 128 (code 2), write then read same word back-to-back
        t_mode(1'b0, 2'b01, 2'b10);
        t_addr(1'b0, 8'h00);
        t_addr(1'b1, 8'h00);
        t_write(1'b1, 8'h5E);
        t_read(1'b0, "R8 code 2 read of word 0");
        t_read(1'b0, "R6 write then read same word");
        t_read(1'b0, "R8 code 2 step 128 word");

        t_idle();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 all reads answered", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule